// File: doc/BRIEF.md
# ADC Window-Check Scan Sequencer

This block runs a fixed eleven-step test that decides whether an analog input lies inside a voltage window. It does this by driving the test-access controls of an on-chip successive-approximation ADC. For each step it presents a parallel vector of ADC control fields: converter enable, DAC code, input multiplexer select, hold, precharge and three port-pin controls. It also presents the scan instruction that must be loaded before that vector is shifted. It then raises `shift_req` toward an external scan shifter and waits for `shift_ack`. The acknowledge carries the comparator bit that was scanned out.

The DAC idles at midpoint. Hold is pulsed low twice to sample the input. Precharge is pulsed low once for each comparison. The comparator is checked against a lower and an upper window code. Both codes are computed at elaboration from integer parameters: input voltage, tolerance and reference. At the end the block pulses `done` for one cycle and reports either pass or fail.

The controller has three states:
- `ST_IDLE` goes to `ST_SHIFT` on `start`.
- `ST_SHIFT` stays in place while waiting. On each `shift_ack` it advances the step, and on the acknowledge of step 11 it goes to `ST_DONE`.
- `ST_DONE` always returns to `ST_IDLE` after one cycle.

Top module: `adc_window_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it drops, the outputs are at their reset values. `shift_req`, `done`, `pass` and `fail` are 0. The vector shows the step-1 values: enable 1, DAC 0x200, mux 0x08, hold 1, precharge 1, pin bits 0, and instruction code 0.
- R2: A `start` seen in `ST_IDLE` makes `shift_req` high in the next cycle with the step-1 vector. `scan_instr` is 0 (preload) in step 1 and 1 (external test) in steps 2 to 11.
- R3: In every step, `adc_en` is 1, `mux_sel` is 0x08 (input channel 3), and `pin_data`, `pin_dir` and `pin_pull` are 0.
- R4: `dac_code` is the lower limit code in steps 4 and 5, the upper limit code in steps 9 and 10, and the midpoint (1 << (DAC_W-1)) in all other steps. `hold` is 0 only in steps 2 and 7, and the DAC is at midpoint whenever hold is 0.
- R5: `prech` is 0 only in steps 5 and 10 and is 1 in all other steps.
- R6: While `shift_ack` is low, `shift_req` and the vector stay unchanged. An acknowledge moves to the next step's vector one cycle later. An acknowledge while `shift_req` is low has no effect.
- R7: The lower code is floor(2^DAC_W × VIN_MV × (100−TOL_PCT) / (100 × VREF_MV)). The upper code is the same expression with (100+TOL_PCT), rounded up. Both are clamped to 0..2^DAC_W−1. The defaults give 291 and 323.
- R8: The `scan_comp` value taken with the acknowledge of step 6 must be 0, and the one taken with step 11 must be 1. Comparator values in all other steps are ignored.
- R9: One cycle after the step-11 acknowledge, `done` is high for exactly one cycle. At that point `pass`=1 and `fail`=0 if both checks held, and otherwise `pass`=0 and `fail`=1. Both flags hold until the next accepted start. The vector returns to the step-1 values.
- R10: `start` is ignored in `ST_SHIFT` and in `ST_DONE`.
- R11: Counted across steps and across back-to-back sequences, hold stays high for at most five consecutive shifted steps. The parameters satisfy run × SCAN_LEN × TCK_PERIOD_NS ≤ HOLD_MAX_NS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a sequence (accepted in idle) |
| shift_ack | input | 1 | Scan shift of the current vector finished |
| scan_comp | input | 1 | Comparator bit scanned out, valid with shift_ack |
| shift_req | output | 1 | Request to shift the current vector |
| scan_instr | output | 1 | Instruction for this step: 0 preload, 1 external test |
| adc_en | output | 1 | ADC enable field |
| dac_code | output | DAC_W | DAC code field |
| mux_sel | output | MUX_W | Input multiplexer select field |
| hold | output | 1 | Hold field (0 = sample) |
| prech | output | 1 | Precharge field (active low) |
| pin_data | output | 1 | Port pin data field |
| pin_dir | output | 1 | Port pin direction field |
| pin_pull | output | 1 | Port pin pull-up enable field |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Window check passed |
| fail | output | 1 | Window check failed |

## Verification
The hardest situation to reach is a `start` or stray comparator value arriving exactly when it could corrupt the result. The cases are:
- a `start` during the single `ST_DONE` cycle;
- a `start` while a step is stalled waiting for its acknowledge;
- a nonzero comparator bit in a step whose value must be ignored.

The bench sweeps every combination of the two decision bits and of the "ignored" comparator value, with and without acknowledge stalls. During stalls it pokes `start`, and in half of the runs it places a `start` in the done cycle. A second instance whose upper limit saturates is run in lock-step to cover the clamp.

// File: rtl/adc_wseq_pkg.sv
package adc_wseq_pkg;

    localparam int NUM_STEPS = 11;
    localparam int STEP_W    = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_DONE  = 2'd2
    } seq_state_t;

    typedef enum logic {
        INSTR_PRELOAD = 1'b0,
        INSTR_EXTEST  = 1'b1
    } scan_instr_t;

    // Window limit code; the lower edge rounds down, the upper edge rounds up,
    // so the accepted window never shrinks; result clamped to the DAC range.
    function automatic int unsigned limit_code(
        input int unsigned vin_mv,
        input int unsigned tol_pct,
        input int unsigned vref_mv,
        input int unsigned dac_w,
        input bit          upper
    );
        longint unsigned full;
        longint unsigned factor;
        longint unsigned num;
        longint unsigned den;
        longint unsigned q;
        full = longint'(1) << dac_w;
        if (upper)
            factor = 100 + longint'(tol_pct);
        else
            factor = (tol_pct >= 100) ? 0 : 100 - longint'(tol_pct);
        num = full * longint'(vin_mv) * factor;
        den = 100 * longint'(vref_mv);
        if (den == 0)
            q = full - 1;
        else if (upper)
            q = (num + den - 1) / den;
        else
            q = num / den;
        if (q > full - 1)
            q = full - 1;
        return int'(q);
    endfunction

endpackage

// File: rtl/adc_wseq_ctrl.sv
module adc_wseq_ctrl
    import adc_wseq_pkg::*;
#(
    parameter int SW   = STEP_W,
    parameter int LAST = NUM_STEPS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          shift_ack,
    output logic [SW-1:0] step,
    output logic          shift_req,
    output logic          done,
    output logic          launch,
    output logic          accept,
    output logic          finish
);

    localparam logic [SW-1:0] FIRST_STEP = SW'(1);
    localparam logic [SW-1:0] LAST_STEP  = SW'(LAST);

    seq_state_t    state_q, state_d;
    logic [SW-1:0] step_q,  step_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            step_q  <= FIRST_STEP;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        step_d  = step_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_SHIFT;
                    step_d  = FIRST_STEP;
                end
            end
            ST_SHIFT: begin
                if (shift_ack) begin
                    if (step_q == LAST_STEP) begin
                        state_d = ST_DONE;
                        step_d  = FIRST_STEP;
                    end else begin
                        step_d = step_q + 1'b1;
                    end
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
                step_d  = FIRST_STEP;
            end
        endcase
    end

    // outputs
    always_comb begin
        step      = step_q;
        shift_req = (state_q == ST_SHIFT);
        done      = (state_q == ST_DONE);
        launch    = (state_q == ST_IDLE) && start;
        accept    = (state_q == ST_SHIFT) && shift_ack;
        finish    = (state_q == ST_SHIFT) && shift_ack && (step_q == LAST_STEP);
    end

    // R6: a pending request keeps its step until acknowledged
    assert_req_held_R6: assert property (@(posedge clk) disable iff (rst)
        (shift_req && !shift_ack) |=> (shift_req && $stable(step)));

    // R9: done is a single-cycle pulse followed by idle
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !shift_req));

    // R10: start in the done cycle does not relaunch
    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (done && start) |=> !shift_req);

endmodule

// File: rtl/adc_wseq_steptab.sv
module adc_wseq_steptab
    import adc_wseq_pkg::*;
#(
    parameter int          SW       = STEP_W,
    parameter int          DAC_W    = 10,
    parameter int          MUX_W    = 5,
    parameter int unsigned MUX_CODE = 8,
    parameter int unsigned LO_CODE  = 291,
    parameter int unsigned HI_CODE  = 323
) (
    input  logic [SW-1:0]    step,
    output logic             instr,
    output logic             adc_en,
    output logic [DAC_W-1:0] dac_code,
    output logic [MUX_W-1:0] mux_sel,
    output logic             hold,
    output logic             prech,
    output logic             pin_data,
    output logic             pin_dir,
    output logic             pin_pull
);

    localparam logic [DAC_W-1:0] DAC_MID = DAC_W'(1) << (DAC_W - 1);
    localparam logic [DAC_W-1:0] DAC_LO  = DAC_W'(LO_CODE);
    localparam logic [DAC_W-1:0] DAC_HI  = DAC_W'(HI_CODE);

    always_comb begin
        adc_en   = 1'b1;
        mux_sel  = MUX_W'(MUX_CODE);
        pin_data = 1'b0;
        pin_dir  = 1'b0;
        pin_pull = 1'b0;
        instr    = (step == SW'(1)) ? INSTR_PRELOAD : INSTR_EXTEST;
        dac_code = DAC_MID;
        hold     = 1'b1;
        prech    = 1'b1;
        unique case (step)
            SW'(2), SW'(7): hold = 1'b0;
            SW'(4):         dac_code = DAC_LO;
            SW'(5): begin
                dac_code = DAC_LO;
                prech    = 1'b0;
            end
            SW'(9):         dac_code = DAC_HI;
            SW'(10): begin
                dac_code = DAC_HI;
                prech    = 1'b0;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/adc_wseq_judge.sv
module adc_wseq_judge
    import adc_wseq_pkg::*;
#(
    parameter int SW      = STEP_W,
    parameter int LO_STEP = 6,
    parameter int HI_STEP = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          launch,
    input  logic          accept,
    input  logic          finish,
    input  logic [SW-1:0] step,
    input  logic          comp,
    output logic          pass,
    output logic          fail
);

    logic err_q;
    logic miss_now;
    logic err_all;

    always_comb begin
        miss_now = accept &&
                   (((step == SW'(LO_STEP)) && comp) ||
                    ((step == SW'(HI_STEP)) && !comp));
        err_all  = err_q || miss_now;
    end

    always_ff @(posedge clk) begin
        if (rst || launch) begin
            err_q <= 1'b0;
            pass  <= 1'b0;
            fail  <= 1'b0;
        end else begin
            if (miss_now)
                err_q <= 1'b1;
            if (finish) begin
                pass <= !err_all;
                fail <= err_all;
            end
        end
    end

    // R9: pass and fail never both set
    assert_flags_excl_R9: assert property (@(posedge clk) disable iff (rst)
        !(pass && fail));

    // R9: a finished sequence leaves exactly one verdict
    assert_verdict_R9: assert property (@(posedge clk) disable iff (rst)
        finish |=> (pass != fail));

    // R8: a wrong low-limit bit always ends as fail
    assert_low_miss_R8: assert property (@(posedge clk) disable iff (rst)
        (accept && step == SW'(LO_STEP) && comp) |=> err_q);

endmodule

// File: rtl/adc_window_seq.sv
module adc_window_seq
    import adc_wseq_pkg::*;
#(
    parameter int          DAC_W         = 10,
    parameter int          MUX_W         = 5,
    parameter int unsigned MUX_CODE      = 8,
    parameter int unsigned VIN_MV        = 1500,
    parameter int unsigned TOL_PCT       = 5,
    parameter int unsigned VREF_MV       = 5000,
    parameter int unsigned SCAN_LEN      = 64,
    parameter int unsigned TCK_PERIOD_NS = 100,
    parameter int unsigned HOLD_MAX_NS   = 100000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             shift_ack,
    input  logic             scan_comp,
    output logic             shift_req,
    output logic             scan_instr,
    output logic             adc_en,
    output logic [DAC_W-1:0] dac_code,
    output logic [MUX_W-1:0] mux_sel,
    output logic             hold,
    output logic             prech,
    output logic             pin_data,
    output logic             pin_dir,
    output logic             pin_pull,
    output logic             done,
    output logic             pass,
    output logic             fail
);

    localparam int unsigned LO_CODE  = limit_code(VIN_MV, TOL_PCT, VREF_MV, DAC_W, 1'b0);
    localparam int unsigned HI_CODE  = limit_code(VIN_MV, TOL_PCT, VREF_MV, DAC_W, 1'b1);
    localparam int unsigned HOLD_RUN = 5;
    localparam logic [DAC_W-1:0] DAC_MID = DAC_W'(1) << (DAC_W - 1);

    logic [STEP_W-1:0] step;
    logic              launch;
    logic              accept;
    logic              finish;

    adc_wseq_ctrl #(
        .SW   (STEP_W),
        .LAST (NUM_STEPS)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .shift_ack (shift_ack),
        .step      (step),
        .shift_req (shift_req),
        .done      (done),
        .launch    (launch),
        .accept    (accept),
        .finish    (finish)
    );

    adc_wseq_steptab #(
        .SW       (STEP_W),
        .DAC_W    (DAC_W),
        .MUX_W    (MUX_W),
        .MUX_CODE (MUX_CODE),
        .LO_CODE  (LO_CODE),
        .HI_CODE  (HI_CODE)
    ) u_tab (
        .step     (step),
        .instr    (scan_instr),
        .adc_en   (adc_en),
        .dac_code (dac_code),
        .mux_sel  (mux_sel),
        .hold     (hold),
        .prech    (prech),
        .pin_data (pin_data),
        .pin_dir  (pin_dir),
        .pin_pull (pin_pull)
    );

    adc_wseq_judge #(
        .SW      (STEP_W),
        .LO_STEP (6),
        .HI_STEP (NUM_STEPS)
    ) u_judge (
        .clk    (clk),
        .rst    (rst),
        .launch (launch),
        .accept (accept),
        .finish (finish),
        .step   (step),
        .comp   (scan_comp),
        .pass   (pass),
        .fail   (fail)
    );

    // Run length of hold-high shifted steps, kept across sequences.
    logic [3:0] hold_run_q;
    always_ff @(posedge clk) begin
        if (rst)
            hold_run_q <= '0;
        else if (accept)
            hold_run_q <= hold ? ((hold_run_q == 4'hF) ? hold_run_q : hold_run_q + 1'b1) : '0;
    end

    // R11: hold high no longer than the budget the scan timing allows
    assert_hold_run_R11: assert property (@(posedge clk) disable iff (rst)
        (32'(hold_run_q) <= HOLD_RUN) &&
        (32'(hold_run_q) * SCAN_LEN * TCK_PERIOD_NS <= HOLD_MAX_NS));

    // R4: sample mode only with DAC at midpoint
    assert_hold_mid_R4: assert property (@(posedge clk) disable iff (rst)
        !hold |-> (dac_code == DAC_MID));

    // R3: fixed fields never move
    assert_fixed_fields_R3: assert property (@(posedge clk) disable iff (rst)
        shift_req |-> (adc_en && mux_sel == MUX_W'(MUX_CODE) &&
                       !pin_data && !pin_dir && !pin_pull));

    // R5: precharge and sample never overlap
    assert_prech_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !(!prech && !hold));

endmodule

// File: tb/sim_adc_window_seq.sv
module sim_adc_window_seq;

    localparam int DAC_W = 10;
    localparam int MUX_W = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic shift_ack = 1'b0;
    logic scan_comp = 1'b0;

    always #2 clk = ~clk;

    logic             req0, ins0, en0, hd0, pc0, pd0, pr0, pu0, dn0, ps0, fl0;
    logic [DAC_W-1:0] dac0;
    logic [MUX_W-1:0] mux0;
    logic             req1, ins1, en1, hd1, pc1, pd1, pr1, pu1, dn1, ps1, fl1;
    logic [DAC_W-1:0] dac1;
    logic [MUX_W-1:0] mux1;

    adc_window_seq u0 (
        .clk(clk), .rst(rst), .start(start), .shift_ack(shift_ack), .scan_comp(scan_comp),
        .shift_req(req0), .scan_instr(ins0), .adc_en(en0), .dac_code(dac0), .mux_sel(mux0),
        .hold(hd0), .prech(pc0), .pin_data(pd0), .pin_dir(pr0), .pin_pull(pu0),
        .done(dn0), .pass(ps0), .fail(fl0)
    );

    adc_window_seq #(.VIN_MV(4900), .TOL_PCT(10), .VREF_MV(5000)) u1 (
        .clk(clk), .rst(rst), .start(start), .shift_ack(shift_ack), .scan_comp(scan_comp),
        .shift_req(req1), .scan_instr(ins1), .adc_en(en1), .dac_code(dac1), .mux_sel(mux1),
        .hold(hd1), .prech(pc1), .pin_data(pd1), .pin_dir(pr1), .pin_pull(pu1),
        .done(dn1), .pass(ps1), .fail(fl1)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int hold_run = 0;
    int hold_max = 0;

    // expected limit codes, computed arithmetically (R7)
    int lo0, hi0, lo1, hi1;
    initial begin
        lo0 = (1024 * 1500 * 95) / (100 * 5000);
        hi0 = (1024 * 1500 * 105 + 100 * 5000 - 1) / (100 * 5000);
        lo1 = (1024 * 4900 * 90) / (100 * 5000);
        hi1 = (1024 * 4900 * 110 + 100 * 5000 - 1) / (100 * 5000);
        if (hi1 > 1023) hi1 = 1023;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_dac(input int s, input int lo, input int hi);
        if (s == 4 || s == 5) return lo;
        if (s == 9 || s == 10) return hi;
        return 512;
    endfunction

    task automatic chk_vec(input int s);
        chk(ins0 == (s != 1), "R2 instr u0", int'(ins0), int'(s != 1));
        chk(ins1 == (s != 1), "R2 instr u1", int'(ins1), int'(s != 1));
        chk(en0 && en1, "R3 enable", int'(en0), 1);
        chk(mux0 == 5'h08 && mux1 == 5'h08, "R3 mux", int'(mux0), 8);
        chk(!(pd0 | pr0 | pu0 | pd1 | pr1 | pu1), "R3 pins", int'({pd0, pr0, pu0}), 0);
        chk(int'(dac0) == exp_dac(s, lo0, hi0), "R4/R7 dac u0", int'(dac0), exp_dac(s, lo0, hi0));
        chk(int'(dac1) == exp_dac(s, lo1, hi1), "R4/R7 dac u1", int'(dac1), exp_dac(s, lo1, hi1));
        chk(hd0 == !(s == 2 || s == 7) && hd1 == hd0, "R4 hold", int'(hd0), int'(!(s == 2 || s == 7)));
        chk(pc0 == !(s == 5 || s == 10) && pc1 == pc0, "R5 prech", int'(pc0), int'(!(s == 5 || s == 10)));
    endtask

    task automatic run_seq(input bit lo_b, input bit hi_b, input bit oth, input int stall, input bit poke_done);
        bit exp_pass;
        exp_pass = (lo_b == 1'b0) && (hi_b == 1'b1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int s = 1; s <= 11; s++) begin
            chk(req0 && req1, "R2/R6 shift_req", int'(req0), 1);
            chk_vec(s);
            for (int w = 0; w < stall; w++) begin
                start = 1'b1;                      // R10 poke while stalled
                scan_comp = ~oth;
                @(negedge clk);
                start = 1'b0;
                chk(req0 && req1 && !dn0, "R6/R10 stalled req", int'(req0), 1);
                chk_vec(s);
            end
            if (hd0) hold_run++; else hold_run = 0;
            if (hold_run > hold_max) hold_max = hold_run;
            shift_ack = 1'b1;
            scan_comp = (s == 6) ? lo_b : ((s == 11) ? hi_b : oth);
            @(negedge clk);
            shift_ack = 1'b0;
            scan_comp = 1'b0;
        end
        chk(dn0 && dn1 && !req0, "R9 done", int'(dn0), 1);
        chk(ps0 == exp_pass && ps1 == exp_pass, "R8/R9 pass", int'(ps0), int'(exp_pass));
        chk(fl0 == !exp_pass && fl1 == !exp_pass, "R8/R9 fail", int'(fl0), int'(!exp_pass));
        chk_vec(1);
        if (poke_done) start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(!dn0 && !dn1, "R9 done one cycle", int'(dn0), 0);
        chk(!req0 && !req1, "R10 start in done ignored", int'(req0), 0);
        chk(ps0 == exp_pass && fl0 == !exp_pass, "R9 flags held", int'(ps0), int'(exp_pass));
        @(negedge clk);
        chk(!req0 && ps0 == exp_pass, "R9 idle after done", int'(req0), 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R6 actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!req0 && !dn0 && !ps0 && !fl0 && !req1 && !dn1, "R1 reset outputs", int'({req0, dn0, ps0, fl0}), 0);
        chk_vec(1);
        rst = 1'b0;
        @(negedge clk);
        chk(!req0 && !ps0 && !fl0, "R1 after reset", int'(req0), 0);
        chk(lo0 == 291 && hi0 == 323 && lo1 == 903 && hi1 == 1023, "R7 bench codes", lo0, 291);
        // R6: acknowledge in idle has no effect
        shift_ack = 1'b1;
        scan_comp = 1'b1;
        @(negedge clk);
        shift_ack = 1'b0;
        scan_comp = 1'b0;
        @(negedge clk);
        chk(!req0 && !dn0 && !ps0 && !fl0, "R6 idle ack ignored", int'({req0, dn0}), 0);
        chk_vec(1);
        for (int lo = 0; lo < 2; lo++)
            for (int hi = 0; hi < 2; hi++)
                for (int ot = 0; ot < 2; ot++)
                    for (int st = 0; st < 3; st += 2)
                        run_seq(lo[0], hi[0], ot[0], st, ot[0]);
        chk(hold_max == 5, "R11 hold run", hold_max, 5);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule